// File: doc/BRIEF.md
# VGA Sync and Pixel Address Generator

This block produces the horizontal and vertical sync pulses for a 640 by 480 raster driven by a 25 MHz pixel clock. It also issues the read address that fetches each pixel from a video refresh memory. A horizontal counter runs freely from 0 to 799 and wraps. A vertical counter advances by one only at the end of each line, so it counts lines 0 to 520. Each sync output comes from a flag that is set when its counter is at zero and cleared when the counter reaches the pulse width. Because the pulse starts at count zero, every line is laid out as sync, back porch, visible pixels, front porch, and every frame follows the same order in lines.

In the visible region the counters give a column and a row. The address is row times the visible width plus column, and it is driven in the same clock as the counter position. A memory with one clock of read latency returns the 3-bit pixel on `pix_i` one clock later. The block registers that value onto `rgb`, so `rgb`, `disp_en` and both sync outputs all describe the counter position of two clocks earlier. Outside the visible region the colour is forced to zero. A one-clock `frame_end` strobe marks the wrap of the vertical counter.

Default timing: horizontal 96 sync, 48 back porch, 640 visible, 16 front porch (800 clocks). Vertical 2 sync, 29 back porch, 480 visible, 10 front porch (521 lines).

Top module: `vga_sync_gen`

## Requirements
- R1: A synchronous active-high `rst` clears both counters, both sync flags and the output pipeline. In the clock after a reset edge and the clock after that, `hsync_n` and `vsync_n` are 1, and `disp_en`, `rgb` and `frame_end` are 0.
- R2: With n the number of clocks since the last reset edge, the horizontal count is n mod H_TOTAL. `hsync_n` is 0 exactly when n ≥ 2 and ((n−2) mod H_TOTAL) < H_SYNC. It is active low, with a period of H_TOTAL clocks and a width of H_SYNC clocks.
- R3: The vertical count advances only when the horizontal count wraps, so it is (n div H_TOTAL) mod V_TOTAL. `vsync_n` is 0 exactly when n ≥ 2 and the vertical count of clock n−2 is below V_SYNC, which is V_SYNC whole lines. It falls in the same clock as `hsync_n`.
- R4: `frame_end` is 1 for one clock per frame, in the clocks where n > 0 and n mod (H_TOTAL·V_TOTAL) = 0. That is the clock after the vertical count wraps from V_TOTAL−1 to 0, and it comes two clocks before `vsync_n` falls.
- R5: The visible counter positions have a horizontal count from H_SYNC+H_BACK to H_SYNC+H_BACK+H_VIS−1 (144 to 783 by default) and a vertical count from V_SYNC+V_BACK to V_SYNC+V_BACK+V_VIS−1 (31 to 510 by default). `disp_en` in clock n is 1 exactly when the position of clock n−2 was visible (n ≥ 2).
- R6: `mem_addr` in clock n is row·H_VIS + column for a visible position of clock n, and 0 otherwise. The column is the horizontal count minus H_SYNC+H_BACK, and the row is the vertical count minus V_SYNC+V_BACK.
- R7: `rgb` in clock n equals the `pix_i` value sampled at the clock edge that ends clock n−1 when `disp_en` is 1. With a one-clock-latency memory, that is the word at the address issued in clock n−2. `rgb` is 0 whenever `disp_en` is 0, whatever `pix_i` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_i | input | PIX_W (3) | Pixel word returned by the refresh memory |
| mem_addr | output | AW (19 at defaults) | Read address for the refresh memory |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| disp_en | output | 1 | High while a visible pixel is on the colour outputs |
| rgb | output | PIX_W (3) | Registered pixel colour, zero during blanking |
| frame_end | output | 1 | One-clock strobe after the last line of a frame |

## Verification
The hardest case to reach is the frame boundary: the vertical counter wrap, `frame_end`, and the alignment of `vsync_n` with `hsync_n`. At full size a frame takes 416,800 clocks. The bench therefore runs a second instance with very short porches, pulses and visible sizes, whose frame is 204 clocks. It checks every output in every clock over hundreds of frames, and the full-size instance alongside it covers the first lines with its vertical pulse and its first visible rows. A reset in the middle of a line then shows that both instances restart from a clean state.

// File: rtl/vga_sync_gen.sv
module vga_sync_gen #(
  parameter int H_SYNC  = 96,
  parameter int H_BACK  = 48,
  parameter int H_VIS   = 640,
  parameter int H_FRONT = 16,
  parameter int V_SYNC  = 2,
  parameter int V_BACK  = 29,
  parameter int V_VIS   = 480,
  parameter int V_FRONT = 10,
  parameter int PIX_W   = 3,
  localparam int AW     = $clog2(H_VIS * V_VIS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PIX_W-1:0] pix_i,
  output logic [AW-1:0]    mem_addr,
  output logic             hsync_n,
  output logic             vsync_n,
  output logic             disp_en,
  output logic [PIX_W-1:0] rgb,
  output logic             frame_end
);
  localparam int H_TOTAL = H_SYNC + H_BACK + H_VIS + H_FRONT;
  localparam int V_TOTAL = V_SYNC + V_BACK + V_VIS + V_FRONT;
  localparam int HW      = $clog2(H_TOTAL);
  localparam int VW      = $clog2(V_TOTAL);
  localparam int H_ON    = H_SYNC + H_BACK;
  localparam int H_OFF   = H_ON + H_VIS;
  localparam int V_ON    = V_SYNC + V_BACK;
  localparam int V_OFF   = V_ON + V_VIS;

  logic [HW-1:0]    hcnt;
  logic [VW-1:0]    vcnt;
  logic             hs_flag, vs_flag;
  logic             hs_q, vs_q;
  logic             vis_d, de_q, eof_q;
  logic [PIX_W-1:0] rgb_q;

  wire line_end   = (hcnt == HW'(H_TOTAL - 1));
  wire frame_last = (vcnt == VW'(V_TOTAL - 1));

  always_ff @(posedge clk) begin
    if (rst)           hcnt <= '0;
    else if (line_end) hcnt <= '0;
    else               hcnt <= hcnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)           vcnt <= '0;
    else if (line_end) vcnt <= frame_last ? '0 : vcnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                         hs_flag <= 1'b0;
    else if (hcnt == '0)             hs_flag <= 1'b1;
    else if (hcnt == HW'(H_SYNC))    hs_flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) vs_flag <= 1'b0;
    else if (hcnt == '0) begin
      if (vcnt == '0)                vs_flag <= 1'b1;
      else if (vcnt == VW'(V_SYNC))  vs_flag <= 1'b0;
    end
  end

  wire h_in = (32'(hcnt) >= H_ON) && (32'(hcnt) < H_OFF);
  wire v_in = (32'(vcnt) >= V_ON) && (32'(vcnt) < V_OFF);
  wire vis  = h_in && v_in;

  wire [HW-1:0] col = hcnt - HW'(H_ON);
  wire [VW-1:0] row = vcnt - VW'(V_ON);

  assign mem_addr = vis ? (AW'(row) * AW'(H_VIS) + AW'(col)) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_q  <= 1'b0;
      vs_q  <= 1'b0;
      vis_d <= 1'b0;
      de_q  <= 1'b0;
      rgb_q <= '0;
      eof_q <= 1'b0;
    end else begin
      hs_q  <= hs_flag;
      vs_q  <= vs_flag;
      vis_d <= vis;
      de_q  <= vis_d;
      rgb_q <= vis_d ? pix_i : '0;
      eof_q <= line_end && frame_last;
    end
  end

  assign hsync_n   = ~hs_q;
  assign vsync_n   = ~vs_q;
  assign disp_en   = de_q;
  assign rgb       = rgb_q;
  assign frame_end = eof_q;

  AST_RESET_IDLE: assert property (@(posedge clk) $past(rst) |-> (hsync_n && vsync_n && !disp_en && !frame_end)); // R1
  AST_LINE_WRAP: assert property (@(posedge clk) disable iff (rst) line_end |=> (hcnt == '0)); // R2
  AST_HS_HOLD: assert property (@(posedge clk) disable iff (rst) (hcnt != '0 && hcnt != HW'(H_SYNC)) |=> $stable(hs_flag)); // R2
  AST_VCNT_HOLD: assert property (@(posedge clk) disable iff (rst) !line_end |=> $stable(vcnt)); // R3
  AST_VS_WITH_HS: assert property (@(posedge clk) disable iff (rst) $fell(vsync_n) |-> $fell(hsync_n)); // R3
  AST_EOF_SINGLE: assert property (@(posedge clk) disable iff (rst) frame_end |=> !frame_end); // R4
  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (rst) 32'(mem_addr) < H_VIS * V_VIS); // R6
  AST_BLANK_DARK: assert property (@(posedge clk) disable iff (rst) !disp_en |-> (rgb == '0)); // R7
endmodule

// File: tb/tb_vga_sync_gen.sv
module tb_vga_sync_gen;
  localparam int CLK_PERIOD = 10;

  localparam int S_HS = 4, S_HB = 3, S_HV = 8, S_HF = 2;
  localparam int S_VS = 2, S_VB = 3, S_VV = 5, S_VF = 2;
  localparam int S_AW = $clog2(S_HV * S_VV);
  localparam int D_AW = $clog2(640 * 480);

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [2:0]      s_pix, d_pix;
  logic [S_AW-1:0] s_addr;
  logic [D_AW-1:0] d_addr;
  logic s_hs, s_vs, s_de, s_eof, d_hs, d_vs, d_de, d_eof;
  logic [2:0] s_rgb, d_rgb;

  vga_sync_gen #(.H_SYNC(S_HS), .H_BACK(S_HB), .H_VIS(S_HV), .H_FRONT(S_HF),
                 .V_SYNC(S_VS), .V_BACK(S_VB), .V_VIS(S_VV), .V_FRONT(S_VF), .PIX_W(3))
    dut (.clk(clk), .rst(rst), .pix_i(s_pix), .mem_addr(s_addr), .hsync_n(s_hs),
         .vsync_n(s_vs), .disp_en(s_de), .rgb(s_rgb), .frame_end(s_eof));

  vga_sync_gen full (.clk(clk), .rst(rst), .pix_i(d_pix), .mem_addr(d_addr), .hsync_n(d_hs),
                     .vsync_n(d_vs), .disp_en(d_de), .rgb(d_rgb), .frame_end(d_eof));

  function automatic logic [2:0] pat(int a);
    return 3'((a ^ (a >> 3) ^ (a >> 5) ^ 5) & 7);
  endfunction

  always @(posedge clk) begin
    s_pix <= pat(int'(s_addr));
    d_pix <= pat(int'(d_addr));
  end

  int n = 0;
  bit started = 0;
  always @(posedge clk) begin
    n <= rst ? 0 : n + 1;
    started <= 1'b1;
  end

  int vectors = 0;
  int miscompares = 0;

  task automatic cmp(string who, string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s %s n=%0d actual=%0d expected=%0d", who, req, what, n, act, exp);
    end
  endtask

  function automatic bit vis_at(int k, int hs, int hb, int hv, int hf, int vs, int vb, int vv, int vf);
    int ht = hs + hb + hv + hf;
    int vt = vs + vb + vv + vf;
    int h = k % ht;
    int v = (k / ht) % vt;
    return (h >= hs + hb) && (h < hs + hb + hv) && (v >= vs + vb) && (v < vs + vb + vv);
  endfunction

  function automatic int addr_at(int k, int hs, int hb, int hv, int hf, int vs, int vb, int vv, int vf);
    int ht = hs + hb + hv + hf;
    int vt = vs + vb + vv + vf;
    int h = k % ht;
    int v = (k / ht) % vt;
    return (v - vs - vb) * hv + (h - hs - hb);
  endfunction

  task automatic check(string who, int hs, int hb, int hv, int hf, int vs, int vb, int vv, int vf,
                       logic ahs, logic avs, logic ade, logic [2:0] argb, int aaddr, logic aeof);
    int ht = hs + hb + hv + hf;
    int vt = vs + vb + vv + vf;
    bit early = (n < 2);
    bit e_hs = !(!early && ((n - 2) % ht) < hs);
    bit e_vs = !(!early && (((n - 2) / ht) % vt) < vs);
    bit e_de = !early && vis_at(n - 2, hs, hb, hv, hf, vs, vb, vv, vf);
    int e_rgb = e_de ? int'(pat(addr_at(n - 2, hs, hb, hv, hf, vs, vb, vv, vf))) : 0;
    int e_addr = vis_at(n, hs, hb, hv, hf, vs, vb, vv, vf) ? addr_at(n, hs, hb, hv, hf, vs, vb, vv, vf) : 0;
    bit e_eof = (n > 0) && (n % (ht * vt) == 0);
    cmp(who, early ? "R1" : "R2", "hsync_n", int'(ahs), int'(e_hs));
    cmp(who, early ? "R1" : "R3", "vsync_n", int'(avs), int'(e_vs));
    cmp(who, early ? "R1" : "R5", "disp_en", int'(ade), int'(e_de));
    cmp(who, early ? "R1" : "R7", "rgb", int'(argb), e_rgb);
    cmp(who, "R6", "mem_addr", aaddr, e_addr);
    cmp(who, early ? "R1" : "R4", "frame_end", int'(aeof), int'(e_eof));
  endtask

  bit run_full = 1;
  always @(negedge clk) begin
    if (started) begin
      check("small", S_HS, S_HB, S_HV, S_HF, S_VS, S_VB, S_VV, S_VF,
            s_hs, s_vs, s_de, s_rgb, int'(s_addr), s_eof);
      if (run_full)
        check("full", 96, 48, 640, 16, 2, 29, 480, 10,
              d_hs, d_vs, d_de, d_rgb, int'(d_addr), d_eof);
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (62000) @(negedge clk);
    repeat (9) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    repeat (1500) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule